// File: doc/BRIEF.md
# Timer Core with Software-Forced Events

This block is a compact general-purpose timer. It has a prescaler, a 16-bit counter that can count up, count down or run center-aligned, an auto-reload limit, and four capture/compare channels. Software reaches it through a single-cycle register write port and a combinational read port. The block raises a level interrupt and a set of single-cycle DMA request pulses.

Its main feature is an event register whose bits software writes to force timer events: an update, a capture/compare on any channel, a commutation of the complementary-channel configuration, and a trigger. Each written bit acts once, on the clock cycle that follows the write, and then clears itself. A forced update restarts the counter and the prescaler. A forced capture on an input channel takes a sample of the counter. A commutation moves the staged channel configuration into its working copy, but only when preload control is on.

Register addresses: 0 control, 1 interrupt enable, 2 DMA enable, 3 status, 4 event, 5 channel direction, 6 prescaler, 7 auto-reload, 8 counter (read only), 9 to 12 channel 1 to 4 compare/capture, 13 staged channel configuration, 14 working channel configuration.

Top module: `tim_evgen_top`

## Requirements
- R1: The event register (address 4) uses these bits: bit 0 update, bits 1 to 4 the channel 1 to 4 capture/compare events, bit 5 commutation, bit 6 trigger. A bit written as 1 takes effect in the cycle after the write, so its results are visible after the second rising edge from the write. The bit then clears itself, and the register always reads as 0.
- R2: Writing 0 to an event bit has no effect on flags, counter or channel registers.
- R3: A trigger event sets status bit 6.
- R4: A forced update sets status bit 0. It loads the counter with 0 when counting up (control bit 1 = 0) or in center mode (control bit 2 = 1), and otherwise with the staged auto-reload value. It restarts the prescaler count and copies the staged prescaler and auto-reload values into their working copies.
- R5: A forced event on an output channel (bit ch-1 of address 5 = 0) sets status bit ch and leaves that channel's register at addresses 9 to 12 unchanged.
- R6: A forced event on an input channel (bit ch-1 of address 5 = 1) copies the counter into the channel register and sets status bit ch. If status bit ch was already set, it also sets overcapture status bit 8+ch.
- R7: A commutation event sets status bit 5. When control bit 3 is 1, it copies the staged configuration (address 13, 4 bits for each of channels 1 to 3) into the working configuration (address 14), which otherwise holds its value. When control bit 3 is 0, a write to address 13 also updates address 14 directly.
- R8: Writing 0 to a status bit clears it and writing 1 keeps it. A hardware set in the same cycle wins over a clear. Reset clears all registers except auto-reload, which resets to all ones.
- R9: irq is high while any status bit 0 to 6 is set together with the matching bit of the interrupt enable register (address 1).
- R10: dma_req[k] pulses for one cycle, in the same cycle that status bit k rises from an event, when bit k of the DMA enable register (address 2) is set.
- R11: With control bit 0 set, the prescaler gives one count step every PSC+1 cycles. Counting up runs 0 to ARR and wraps to 0. Counting down runs to 0 and reloads the staged ARR. Center mode turns at ARR and at 0. Each wrap or turn is a natural update, which transfers the staged values. The counter reads at address 8.
- R12: When update and channel events are written together, the update is applied first, so captures taken in that cycle see the reinitialized counter value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 16 | Combinational read data |
| irq | output | 1 | Interrupt request level |
| dma_req | output | 7 | Per-event DMA request pulses |

## Verification
The assertions assume that software uses a whole status word when clearing flags. They also assume that an event launched by a write is not contradicted by a control change in the same cycle, except in the ways R8 and R12 define. The stimulus writes each register with a full word and idles between phases. It keeps the auto-reload value at 1 or more while the counter runs in center mode. Same-cycle combinations are reached only by multi-bit event writes and by status writes that race a pending event.

// File: rtl/tim_pkg.sv
package tim_pkg;
    localparam int ADDR_W  = 4;
    localparam int NCH     = 4;
    localparam int NEV     = NCH + 3;
    localparam int NCMP    = 3;
    localparam int CEW     = 4;
    localparam int CFGW    = NCMP * CEW;
    localparam int OVC_LSB = 9;
    localparam int EV_UPD  = 0;
    localparam int EV_COM  = NCH + 1;
    localparam int EV_TRG  = NCH + 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
    localparam logic [ADDR_W-1:0] A_IEN  = 4'd1;
    localparam logic [ADDR_W-1:0] A_DEN  = 4'd2;
    localparam logic [ADDR_W-1:0] A_STAT = 4'd3;
    localparam logic [ADDR_W-1:0] A_EVG  = 4'd4;
    localparam logic [ADDR_W-1:0] A_CHIN = 4'd5;
    localparam logic [ADDR_W-1:0] A_PSC  = 4'd6;
    localparam logic [ADDR_W-1:0] A_ARR  = 4'd7;
    localparam logic [ADDR_W-1:0] A_CNT  = 4'd8;
    localparam logic [ADDR_W-1:0] A_CCR0 = 4'd9;
    localparam logic [ADDR_W-1:0] A_CFGS = 4'd13;
    localparam logic [ADDR_W-1:0] A_CFGA = 4'd14;
endpackage

// File: rtl/tim_prescaler.sv
module tim_prescaler #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          clr,
    input  logic [DW-1:0] ratio,
    output logic          tick
);
    typedef struct packed {
        logic [DW-1:0] cnt;
    } psc_t;

    psc_t psc_d, psc_q;

    always_comb begin
        psc_d = psc_q;
        tick  = 1'b0;
        if (clr) begin
            psc_d.cnt = '0;
        end else if (en) begin
            if (psc_q.cnt >= ratio) begin
                psc_d.cnt = '0;
                tick      = 1'b1;
            end else begin
                psc_d.cnt = psc_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) psc_q <= '0;
        else        psc_q <= psc_d;
    end
endmodule

// File: rtl/tim_counter.sv
module tim_counter #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          down,
    input  logic          center,
    input  logic [DW-1:0] top,
    input  logic [DW-1:0] reload,
    output logic [DW-1:0] cnt,
    output logic          wrap
);
    typedef struct packed {
        logic [DW-1:0] cnt;
        logic          up;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        wrap  = 1'b0;
        if (load) begin
            ctr_d.cnt = load_val;
            ctr_d.up  = 1'b1;
        end else if (tick) begin
            if (center) begin
                if (top == '0) begin
                    ctr_d.cnt = '0;
                    wrap      = 1'b1;
                end else if (ctr_q.up) begin
                    if (ctr_q.cnt >= top) begin
                        ctr_d.cnt = top - 1'b1;
                        ctr_d.up  = 1'b0;
                        wrap      = 1'b1;
                    end else begin
                        ctr_d.cnt = ctr_q.cnt + 1'b1;
                    end
                end else if (ctr_q.cnt == '0) begin
                    ctr_d.cnt = {{(DW-1){1'b0}}, 1'b1};
                    ctr_d.up  = 1'b1;
                    wrap      = 1'b1;
                end else begin
                    ctr_d.cnt = ctr_q.cnt - 1'b1;
                end
            end else if (down) begin
                if (ctr_q.cnt == '0) begin
                    ctr_d.cnt = reload;
                    wrap      = 1'b1;
                end else begin
                    ctr_d.cnt = ctr_q.cnt - 1'b1;
                end
            end else if (ctr_q.cnt >= top) begin
                ctr_d.cnt = '0;
                wrap      = 1'b1;
            end else begin
                ctr_d.cnt = ctr_q.cnt + 1'b1;
            end
        end
    end

    assign cnt = ctr_q.cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) ctr_q <= '{cnt: '0, up: 1'b1};
        else        ctr_q <= ctr_d;
    end
endmodule

// File: rtl/tim_evgen_top.sv
module tim_evgen_top
    import tim_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    output logic              irq,
    output logic [NEV-1:0]    dma_req
);
    typedef struct packed {
        logic                    en;
        logic                    down;
        logic                    center;
        logic                    ccpc;
        logic [NEV-1:0]          ien;
        logic [NEV-1:0]          den;
        logic [NEV-1:0]          flags;
        logic [NEV-1:0]          ev;
        logic [NEV-1:0]          dma;
        logic [NCH-1:0]          ovc;
        logic [NCH-1:0]          chin;
        logic [DW-1:0]           psc_pre;
        logic [DW-1:0]           arr_pre;
        logic [DW-1:0]           psc_sh;
        logic [DW-1:0]           arr_sh;
        logic [NCH-1:0][DW-1:0]  ccr;
        logic [CFGW-1:0]         cfg_pre;
        logic [CFGW-1:0]         cfg_act;
    } st_t;

    st_t st_d, st_q;

    logic          tick, wrap, upd;
    logic [DW-1:0] cnt, load_val, capv;
    logic [NEV-1:0] set;

    assign load_val = (st_q.center || !st_q.down) ? '0 : st_q.arr_pre;
    assign capv     = st_q.ev[EV_UPD] ? load_val : cnt;
    assign upd      = st_q.ev[EV_UPD] | wrap;

    tim_prescaler #(.DW(DW)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (st_q.en),
        .clr   (st_q.ev[EV_UPD]),
        .ratio (st_q.psc_sh),
        .tick  (tick)
    );

    tim_counter #(.DW(DW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (st_q.ev[EV_UPD]),
        .load_val (load_val),
        .down     (st_q.down),
        .center   (st_q.center),
        .top      (st_q.arr_sh),
        .reload   (st_q.arr_pre),
        .cnt      (cnt),
        .wrap     (wrap)
    );

    always_comb begin
        st_d    = st_q;
        st_d.ev = '0;
        set     = '0;
        if (wr_en) begin
            case (wr_addr)
                A_CTRL: {st_d.ccpc, st_d.center, st_d.down, st_d.en} = wr_data[3:0];
                A_IEN:  st_d.ien = wr_data[NEV-1:0];
                A_DEN:  st_d.den = wr_data[NEV-1:0];
                A_STAT: begin
                    st_d.flags = st_q.flags & wr_data[NEV-1:0];
                    st_d.ovc   = st_q.ovc & wr_data[OVC_LSB +: NCH];
                end
                A_EVG:  st_d.ev = wr_data[NEV-1:0];
                A_CHIN: st_d.chin = wr_data[NCH-1:0];
                A_PSC:  st_d.psc_pre = wr_data;
                A_ARR:  st_d.arr_pre = wr_data;
                A_CFGS: begin
                    st_d.cfg_pre = wr_data[CFGW-1:0];
                    if (!st_q.ccpc) st_d.cfg_act = wr_data[CFGW-1:0];
                end
                default: ;
            endcase
            for (int i = 0; i < NCH; i++) begin
                if (wr_addr == A_CCR0 + ADDR_W'(i)) st_d.ccr[i] = wr_data;
            end
        end
        // forced and natural events are applied after software writes
        set[EV_UPD] = upd;
        if (upd) begin
            st_d.psc_sh = st_q.psc_pre;
            st_d.arr_sh = st_q.arr_pre;
        end
        for (int i = 0; i < NCH; i++) begin
            if (st_q.ev[i+1]) begin
                set[i+1] = 1'b1;
                if (st_q.chin[i]) begin
                    st_d.ccr[i] = capv;
                    if (st_q.flags[i+1]) st_d.ovc[i] = 1'b1;
                end
            end
        end
        if (st_q.ev[EV_COM]) begin
            set[EV_COM] = 1'b1;
            if (st_q.ccpc) st_d.cfg_act = st_q.cfg_pre;
        end
        set[EV_TRG] = st_q.ev[EV_TRG];
        st_d.flags  = st_d.flags | set;
        st_d.dma    = set & st_q.den;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.arr_pre <= '1;
            st_q.arr_sh  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq     = |(st_q.flags & st_q.ien);
    assign dma_req = st_q.dma;

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL: rd_data[3:0] = {st_q.ccpc, st_q.center, st_q.down, st_q.en};
            A_IEN:  rd_data[NEV-1:0] = st_q.ien;
            A_DEN:  rd_data[NEV-1:0] = st_q.den;
            A_STAT: begin
                rd_data[NEV-1:0]        = st_q.flags;
                rd_data[OVC_LSB +: NCH] = st_q.ovc;
            end
            A_CHIN: rd_data[NCH-1:0] = st_q.chin;
            A_PSC:  rd_data = st_q.psc_pre;
            A_ARR:  rd_data = st_q.arr_pre;
            A_CNT:  rd_data = cnt;
            A_CFGS: rd_data[CFGW-1:0] = st_q.cfg_pre;
            A_CFGA: rd_data[CFGW-1:0] = st_q.cfg_act;
            default: ;
        endcase
        for (int i = 0; i < NCH; i++) begin
            if (rd_addr == A_CCR0 + ADDR_W'(i)) rd_data = st_q.ccr[i];
        end
    end

    // R1: a pending event lives exactly one cycle unless written again
    assert_ev_selfclear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.ev != '0) && !(wr_en && wr_addr == A_EVG)) |=> (st_q.ev == '0))
        else $error("event bits did not clear");

    assert_trig_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ev[EV_TRG] |=> st_q.flags[EV_TRG])
        else $error("trigger flag not set");

    assert_upd_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ev[EV_UPD] && (st_q.center || !st_q.down)) |=> (cnt == '0))
        else $error("forced update did not clear counter");

    assert_upd_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ev[EV_UPD] && st_q.down && !st_q.center) |=> (cnt == $past(st_q.arr_pre)))
        else $error("forced update did not reload counter");

    assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ccpc && !st_q.ev[EV_COM]) |=> $stable(st_q.cfg_act))
        else $error("working configuration moved without commutation");

    for (genvar g = 0; g < NCH; g++) begin : g_ovc_chk
        assert_overcapture_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.ev[g+1] && st_q.chin[g] && st_q.flags[g+1]) |=> st_q.ovc[g])
            else $error("overcapture not flagged");
    end

    for (genvar g = 0; g < NEV; g++) begin : g_flag_chk
        assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.flags[g] && !(wr_en && wr_addr == A_STAT && !wr_data[g])) |=> st_q.flags[g])
            else $error("status flag dropped without a clear");
        assert_dma_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.dma[g] |-> $past(st_q.den[g]))
            else $error("DMA pulse without enable");
    end
endmodule

// File: tb/test_tim_evgen_top.sv
module test_tim_evgen_top;
    localparam int CLK_NS = 10;
    localparam int WDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        irq;
    logic [6:0]  dma_req;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;
    string cur_req = "R8";

    always #(CLK_NS/2) clk = ~clk;

    tim_evgen_top i_tim_evgen_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .dma_req(dma_req)
    );

    // behavioural reference state
    int m_en, m_down, m_center, m_ccpc, m_ien, m_den, m_flags, m_ovc, m_ev, m_chin;
    int m_psc_pre, m_arr_pre, m_psc, m_arr, m_pc, m_cnt, m_up, m_cpre, m_cact, m_dma;
    int m_ccr[4];
    int t_ev, t_set, t_upd, t_ld, t_cap, t_ncnt, t_nup, t_npc, t_tick, t_nev;
    int o_flags, o_ccpc, o_cpre, o_den, o_psc_pre, o_arr_pre, o_chin, wd;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_down = 0; m_center = 0; m_ccpc = 0; m_ien = 0; m_den = 0;
            m_flags = 0; m_ovc = 0; m_ev = 0; m_chin = 0; m_psc_pre = 0; m_psc = 0;
            m_arr_pre = 16'hFFFF; m_arr = 16'hFFFF; m_pc = 0; m_cnt = 0; m_up = 1;
            m_cpre = 0; m_cact = 0; m_dma = 0;
            foreach (m_ccr[k]) m_ccr[k] = 0;
        end else begin
            t_ev = m_ev; t_set = 0; t_upd = 0; t_nev = 0;
            t_ld = (m_center != 0 || m_down == 0) ? 0 : m_arr_pre;
            if (t_ev & 1) begin
                t_ncnt = t_ld; t_nup = 1; t_npc = 0; t_upd = 1;
            end else begin
                t_ncnt = m_cnt; t_nup = m_up; t_npc = m_pc; t_tick = 0;
                if (m_en != 0) begin
                    if (m_pc >= m_psc) begin t_npc = 0; t_tick = 1; end
                    else t_npc = m_pc + 1;
                end
                if (t_tick != 0) begin
                    if (m_center != 0) begin
                        if (m_arr == 0) begin t_ncnt = 0; t_upd = 1; end
                        else if (m_up != 0) begin
                            if (m_cnt >= m_arr) begin t_ncnt = m_arr - 1; t_nup = 0; t_upd = 1; end
                            else t_ncnt = m_cnt + 1;
                        end else if (m_cnt == 0) begin t_ncnt = 1; t_nup = 1; t_upd = 1; end
                        else t_ncnt = m_cnt - 1;
                    end else if (m_down != 0) begin
                        if (m_cnt == 0) begin t_ncnt = m_arr_pre; t_upd = 1; end
                        else t_ncnt = m_cnt - 1;
                    end else begin
                        if (m_cnt >= m_arr) begin t_ncnt = 0; t_upd = 1; end
                        else t_ncnt = m_cnt + 1;
                    end
                end
            end
            t_cap = (t_ev & 1) ? t_ld : m_cnt;
            o_flags = m_flags; o_ccpc = m_ccpc; o_cpre = m_cpre; o_den = m_den;
            o_psc_pre = m_psc_pre; o_arr_pre = m_arr_pre; o_chin = m_chin;
            if (wr_en) begin
                wd = int'(wr_data);
                case (int'(wr_addr))
                    0: begin m_en = wd & 1; m_down = (wd >> 1) & 1; m_center = (wd >> 2) & 1; m_ccpc = (wd >> 3) & 1; end
                    1: m_ien = wd & 127;
                    2: m_den = wd & 127;
                    3: begin m_flags = m_flags & wd & 127; m_ovc = m_ovc & (wd >> 9) & 15; end
                    4: t_nev = wd & 127;
                    5: m_chin = wd & 15;
                    6: m_psc_pre = wd;
                    7: m_arr_pre = wd;
                    9, 10, 11, 12: m_ccr[int'(wr_addr) - 9] = wd;
                    13: begin m_cpre = wd & 12'hFFF; if (o_ccpc == 0) m_cact = wd & 12'hFFF; end
                    default: ;
                endcase
            end
            if (t_upd != 0) begin t_set = t_set | 1; m_psc = o_psc_pre; m_arr = o_arr_pre; end
            for (int k = 0; k < 4; k++) begin
                if ((t_ev >> (k + 1)) & 1) begin
                    t_set = t_set | (1 << (k + 1));
                    if ((o_chin >> k) & 1) begin
                        m_ccr[k] = t_cap;
                        if ((o_flags >> (k + 1)) & 1) m_ovc = m_ovc | (1 << k);
                    end
                end
            end
            if ((t_ev >> 5) & 1) begin t_set = t_set | 32; if (o_ccpc != 0) m_cact = o_cpre; end
            if ((t_ev >> 6) & 1) t_set = t_set | 64;
            m_flags = m_flags | t_set;
            m_dma = t_set & o_den;
            m_ev = t_nev; m_cnt = t_ncnt; m_up = t_nup; m_pc = t_npc;
        end
    end

    function automatic int mrd(int a);
        case (a)
            0: return m_en | (m_down << 1) | (m_center << 2) | (m_ccpc << 3);
            1: return m_ien;
            2: return m_den;
            3: return m_flags | (m_ovc << 9);
            5: return m_chin;
            6: return m_psc_pre;
            7: return m_arr_pre;
            8: return m_cnt;
            9, 10, 11, 12: return m_ccr[a - 9];
            13: return m_cpre;
            14: return m_cact;
            default: return 0;
        endcase
    endfunction

    task automatic chk(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk($sformatf("rd_data@%0d", rd_addr), int'(rd_data), mrd(int'(rd_addr)));
            chk("irq", int'(irq), ((m_flags & m_ien) != 0) ? 1 : 0);
            chk("dma_req", int'(dma_req), m_dma);
        end
    end

    task automatic report;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=%0d expected<%0d", cyc, WDOG);
            report();
        end
    end

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // reset state (R8)
        cur_req = "R8"; rd_addr = 4'd7; idle(2); rd_addr = 4'd3; idle(2);
        // counting modes (R11)
        cur_req = "R11"; rd_addr = 4'd8;
        wr(4'd6, 16'd1); wr(4'd7, 16'd5); wr(4'd4, 16'h01); idle(2);
        wr(4'd0, 16'h1); idle(30);
        wr(4'd0, 16'h3); idle(25);
        wr(4'd0, 16'h5); idle(40);
        rd_addr = 4'd3; idle(3);
        // forced update in each mode (R4)
        cur_req = "R4"; rd_addr = 4'd8;
        wr(4'd7, 16'd9); wr(4'd4, 16'h01); idle(5);
        wr(4'd0, 16'h3); wr(4'd4, 16'h01); idle(5);
        wr(4'd0, 16'h5); wr(4'd4, 16'h01); idle(5);
        wr(4'd6, 16'd3); wr(4'd0, 16'h1); idle(2); wr(4'd4, 16'h01); idle(12);
        // trigger (R3)
        cur_req = "R3";
        wr(4'd0, 16'h0); wr(4'd3, 16'h0); wr(4'd1, 16'h40); rd_addr = 4'd3;
        wr(4'd4, 16'h40); idle(3);
        // interrupt combining (R9)
        cur_req = "R9";
        wr(4'd1, 16'h7F); idle(2); wr(4'd1, 16'h0); idle(2); wr(4'd1, 16'h01); idle(2);
        // status write semantics (R8)
        cur_req = "R8";
        wr(4'd3, 16'hFFFF); idle(2); wr(4'd3, 16'hFFBF); idle(2);
        wr(4'd4, 16'h40); wr(4'd3, 16'h0000); idle(2);
        // forced compare on output channel (R5)
        cur_req = "R5";
        wr(4'd5, 16'h0); wr(4'd9, 16'h1234); rd_addr = 4'd9;
        wr(4'd4, 16'h02); idle(3); rd_addr = 4'd3; idle(2);
        // forced capture on input channels, overcapture (R6)
        cur_req = "R6";
        wr(4'd6, 16'd0); wr(4'd7, 16'd20); wr(4'd4, 16'h01); wr(4'd0, 16'h1);
        wr(4'd5, 16'hF); wr(4'd3, 16'h0); rd_addr = 4'd10;
        wr(4'd4, 16'h04); idle(3); wr(4'd4, 16'h04); idle(3);
        rd_addr = 4'd12; wr(4'd4, 16'h10); idle(3);
        rd_addr = 4'd3; idle(2);
        // update and capture together (R12)
        cur_req = "R12";
        wr(4'd0, 16'h3); wr(4'd7, 16'h0020); rd_addr = 4'd11;
        wr(4'd4, 16'h09); idle(3);
        wr(4'd0, 16'h1); wr(4'd4, 16'h0F); idle(3); rd_addr = 4'd9; idle(2);
        // commutation (R7)
        cur_req = "R7"; rd_addr = 4'd14;
        wr(4'd0, 16'h0); wr(4'd13, 16'h0ABC); idle(2);
        wr(4'd0, 16'h8); wr(4'd13, 16'h0123); idle(3);
        wr(4'd4, 16'h20); idle(3);
        wr(4'd13, 16'h0456); wr(4'd0, 16'h0); wr(4'd4, 16'h20); idle(3);
        rd_addr = 4'd3; idle(2);
        // DMA pulses (R10)
        cur_req = "R10";
        wr(4'd2, 16'h7F); wr(4'd4, 16'h7F); idle(3);
        wr(4'd7, 16'd2); wr(4'd4, 16'h01); wr(4'd2, 16'h01); wr(4'd0, 16'h1); idle(20);
        wr(4'd2, 16'h0); idle(4);
        // event register reads zero, one-cycle delay (R1)
        cur_req = "R1"; wr(4'd0, 16'h0); rd_addr = 4'd4;
        wr(4'd4, 16'h40); idle(2); rd_addr = 4'd3; wr(4'd3, 16'h0); wr(4'd4, 16'h7E); idle(2);
        // zero write ignored (R2)
        cur_req = "R2";
        wr(4'd3, 16'h0); rd_addr = 4'd3; wr(4'd4, 16'h0); idle(4);
        rd_addr = 4'd8; idle(2);
        report();
    end
endmodule